// File: doc/BRIEF.md
# Deferred Condition Branch Resolver

This block sits between the ALU and the program counter of a stack processor. It moves the choice of branch condition out of the branch and into the compare instruction that comes before it. A compare subtracts its two operands, which are the top two stack elements. It also carries a 3-bit field that names one flag, or that flag's complement. The block reduces the selected flag to one stored bit at the clock edge.

A later conditional branch does not decode any flags. It tests only the stored bit and picks either its target or the fall-through address. The next program counter is produced combinationally in the same cycle as the branch strobe, so a branch resolves in one cycle and needs no delay slot. An unconditional jump takes its target whatever the stored bit holds.

Top module: `dcb_unit`

## Requirements
- R1: After synchronous reset the stored condition bit is 0, so a conditional branch issued before any compare is not taken.
- R2: When `cmp_valid` is high at a rising clock edge, the selected condition is stored at that edge and appears on `cond_bit` from the following cycle.
- R3: The flags come from `cmp_a - cmp_b` at DATA_W bits. Z is 1 when the difference is zero. N is the most significant bit of the difference. C is 1 when `cmp_a >= cmp_b` unsigned, meaning no borrow. V is 1 on two's-complement overflow of the subtraction.
- R4: `cmp_sel[1:0]` picks the flag: 00 selects Z, 01 selects N, 10 selects C and 11 selects V. When `cmp_sel[2]` is 1 the picked flag is inverted.
- R5: The stored bit keeps its value until the next compare. Idle cycles, conditional branches and jumps leave it unchanged.
- R6: With `br_cond` high and `br_jump` low, `br_taken` equals the stored bit. When it is taken, `next_pc` equals `br_target` in the same cycle.
- R7: Whenever no branch is taken, `next_pc` is `cur_pc + 1` modulo 2^ADDR_W, so all ones wraps to zero.
- R8: With `br_jump` high, `br_taken` is 1 and `next_pc` is `br_target` whatever the stored bit holds. This applies even when `br_cond` is also high.
- R9: When a compare and a conditional branch are in the same cycle, the branch uses the bit stored by the earlier compare. The new result only affects later branches.
- R10: With neither branch strobe high, `br_taken` is 0 and `next_pc` is `cur_pc + 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | A compare instruction executes this cycle |
| cmp_a | input | DATA_W | Minuend: the element below the top of the stack |
| cmp_b | input | DATA_W | Subtrahend: the top of the stack |
| cmp_sel | input | 3 | Condition select: [1:0] flag, [2] invert |
| cur_pc | input | ADDR_W | Address of the current instruction |
| br_cond | input | 1 | A conditional branch executes this cycle |
| br_jump | input | 1 | An unconditional jump executes this cycle |
| br_target | input | ADDR_W | Branch or jump destination |
| next_pc | output | ADDR_W | Address of the next instruction to fetch |
| br_taken | output | 1 | The current branch or jump is redirecting the program counter |
| cond_bit | output | 1 | Stored condition bit |

## Verification
The only internal state is the stored condition bit, and `cond_bit` exposes it directly. A wrong latch value is therefore visible one cycle after the compare that wrote it. It also shows up on `br_taken` and `next_pc` in the first conditional-branch cycle after that compare. A mistake in flag generation or selection appears only for operand pairs that separate the four flags and their complements. For that reason, every select code is applied to equal, lower, higher and signed-overflow operand pairs. Errors in the hold or same-cycle ordering become visible only when a branch follows idle cycles or coincides with a compare, so both cases are driven explicitly.

// File: rtl/dcb_pkg.sv
// Shared types for the deferred condition branch resolver.
// Assumes a 3-bit condition select: two flag bits plus one invert bit.
package dcb_pkg;

    localparam int SEL_W = 3;

    // Flag set produced by one compare subtraction
    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    // Which flag a compare nominates (select bits [1:0])
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_NEG   = 2'b01,
        SRC_CARRY = 2'b10,
        SRC_OVF   = 2'b11
    } flag_src_e;

endpackage

// File: rtl/dcb_flag_gen.sv
// Compare subtractor: computes op_a - op_b and derives Z, N, C, V.
// C means "no borrow" (op_a >= op_b unsigned). Purely combinational;
// clk and rst_n only clock the local assertions.
module dcb_flag_gen #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    output dcb_pkg::flags_t     flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] diff;

    // Subtract as a + ~b + 1 so the carry out is the no-borrow flag
    always_comb begin
        sum_ext = {1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, 1'b1};
        diff    = sum_ext[MSB:0];
    end

    // Derive the four flags from the difference and operand signs
    always_comb begin
        flags.z = (diff == '0);
        flags.n = diff[MSB];
        flags.c = sum_ext[DATA_W];
        flags.v = (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_a[MSB]);
    end

    // R3: zero flag agrees with a direct equality test of the operands
    assert_zero_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags.z == (op_a == op_b));

    // R3: no-borrow flag agrees with an unsigned magnitude comparison
    assert_carry_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags.c == (op_a >= op_b));

endmodule

// File: rtl/dcb_cond_pick.sv
// Reduces the flag set to one bit as named by the compare's select
// field: bits [1:0] choose the flag, bit 2 inverts it. Combinational.
module dcb_cond_pick (
    input  dcb_pkg::flags_t             flags,
    input  logic [dcb_pkg::SEL_W-1:0]   sel,
    output logic                        pick
);
    import dcb_pkg::*;

    logic      raw;
    flag_src_e src;

    // Decode which flag the compare nominated
    always_comb begin
        src = flag_src_e'(sel[1:0]);
        unique case (src)
            SRC_ZERO:  raw = flags.z;
            SRC_NEG:   raw = flags.n;
            SRC_CARRY: raw = flags.c;
            SRC_OVF:   raw = flags.v;
            default:   raw = 1'b0;
        endcase
    end

    // Apply the optional complement
    always_comb pick = raw ^ sel[SEL_W-1];

endmodule

// File: rtl/dcb_cond_reg.sv
// Single stored condition bit. It loads only on a compare and clears
// on synchronous active-low reset. Nothing else writes it.
module dcb_cond_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // Capture the selected condition on a compare, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end

    // R1: the bit is clear in the first cycle after reset is released
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !q);

    // R2: a compare's selected condition appears in the next cycle
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R5: without a compare the bit keeps its value
    assert_hold_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/dcb_pc_mux.sv
// Next-address selector. A jump always takes the target, and a
// conditional branch takes it only when the stored bit is set.
// Otherwise it falls through to pc + 1, wrapping. Combinational;
// clk and rst_n only clock the assertions.
module dcb_pc_mux #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    input  logic              cond_en,
    input  logic              jump_en,
    input  logic              cond_bit,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken
);
    logic [ADDR_W-1:0] fall_through;

    // Sequential successor, modulo the address width
    always_comb fall_through = pc + ADDR_W'(1);

    // Decide redirection: a jump overrides the stored bit
    always_comb taken = jump_en | (cond_en & cond_bit);

    // Select the fetch address for the next cycle
    always_comb next_pc = taken ? target : fall_through;

    // R8: a jump always redirects to the target
    assert_jump_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_en |-> (taken && next_pc == target));

    // R10: no strobe means no redirection
    assert_idle_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_en && !cond_en) |-> !taken);

    // R6: a conditional branch with a clear bit never redirects
    assert_clear_nottaken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_en && !jump_en && !cond_bit) |-> !taken);

endmodule

// File: rtl/dcb_unit.sv
// Top level of the deferred condition branch resolver. A compare
// computes flags, picks one by its select field and stores it as one
// bit. A branch tests only that stored bit, and the next PC comes out
// in the same cycle. Assumes one instruction per cycle; compare and
// branch may coincide, in which case the branch sees the older bit.
module dcb_unit #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmp_valid,
    input  logic [DATA_W-1:0]           cmp_a,
    input  logic [DATA_W-1:0]           cmp_b,
    input  logic [dcb_pkg::SEL_W-1:0]   cmp_sel,
    input  logic [ADDR_W-1:0]           cur_pc,
    input  logic                        br_cond,
    input  logic                        br_jump,
    input  logic [ADDR_W-1:0]           br_target,
    output logic [ADDR_W-1:0]           next_pc,
    output logic                        br_taken,
    output logic                        cond_bit
);
    dcb_pkg::flags_t flags;
    logic            picked;

    dcb_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .flags (flags)
    );

    dcb_cond_pick u_pick (
        .flags (flags),
        .sel   (cmp_sel),
        .pick  (picked)
    );

    dcb_cond_reg u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_valid),
        .d     (picked),
        .q     (cond_bit)
    );

    dcb_pc_mux #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc       (cur_pc),
        .target   (br_target),
        .cond_en  (br_cond),
        .jump_en  (br_jump),
        .cond_bit (cond_bit),
        .next_pc  (next_pc),
        .taken    (br_taken)
    );

    // R9: a branch alongside a compare follows the previously stored bit
    assert_old_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && br_cond && !br_jump) |-> (br_taken == cond_bit));

    // R2: the stored bit changes only in the cycle after a compare
    assert_change_after_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_bit != $past(cond_bit)) |-> $past(cmp_valid));

endmodule

// File: tb/dcb_unit_test.sv
// Directed bench for dcb_unit: one task per scenario. Inputs change
// 1 ns after a rising edge; outputs are sampled before the next edge.
module dcb_unit_test;
    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmp_valid;
    logic [DW-1:0] cmp_a, cmp_b;
    logic [2:0]    cmp_sel;
    logic [AW-1:0] cur_pc;
    logic          br_cond, br_jump;
    logic [AW-1:0] br_target;
    logic [AW-1:0] next_pc;
    logic          br_taken;
    logic          cond_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dcb_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .cmp_sel(cmp_sel), .cur_pc(cur_pc), .br_cond(br_cond),
        .br_jump(br_jump), .br_target(br_target), .next_pc(next_pc),
        .br_taken(br_taken), .cond_bit(cond_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reference condition computed from the requirement text
    function automatic bit model_bit(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                     input logic [2:0] sel);
        int sa, sb, r;
        logic [DW-1:0] d;
        bit f;
        sa = int'($signed(a));
        sb = int'($signed(b));
        r  = sa - sb;
        d  = a - b;
        case (sel[1:0])
            2'd0: f = (a == b);
            2'd1: f = d[DW-1];
            2'd2: f = (a >= b);
            default: f = (r > 32767) || (r < -32768);
        endcase
        return f ^ sel[2];
    endfunction

    task automatic idle_inputs();
        cmp_valid = 0; br_cond = 0; br_jump = 0;
    endtask

    // One compare cycle, then the stored bit is checked
    task automatic do_compare(input logic [DW-1:0] a, input logic [DW-1:0] b,
                              input logic [2:0] sel, input string req);
        cmp_valid = 1; cmp_a = a; cmp_b = b; cmp_sel = sel;
        tick();
        cmp_valid = 0;
        check(cond_bit == model_bit(a, b, sel), req, cond_bit, model_bit(a, b, sel));
    endtask

    task automatic t_reset();
        rst_n = 0; idle_inputs(); cmp_a = '1; cmp_b = 0; cmp_sel = 3'b100;
        cur_pc = 16'h0010; br_target = 16'h0200;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check(cond_bit == 0, "R1 reset bit", cond_bit, 0);
        br_cond = 1; #1;
        check(!br_taken && next_pc == 16'h0011, "R1 branch before compare",
              next_pc, 16'h0011);
        br_cond = 0;
    endtask

    task automatic t_idle();
        cur_pc = 16'h1234; #1;
        check(!br_taken && next_pc == 16'h1235, "R10 no strobe", next_pc, 16'h1235);
    endtask

    // Every select code over operand pairs that separate the flags
    task automatic t_sweep();
        logic [DW-1:0] av [5] = '{16'h0005, 16'h0003, 16'h0009, 16'h7FFF, 16'h8000};
        logic [DW-1:0] bv [5] = '{16'h0005, 16'h0009, 16'h0003, 16'hFFFF, 16'h0001};
        for (int i = 0; i < 5; i++) begin
            for (int s = 0; s < 8; s++) begin
                bit e;
                e = model_bit(av[i], bv[i], 3'(s));
                do_compare(av[i], bv[i], 3'(s), "R2 R3 R4 compare sweep");
                cur_pc = AW'(16'h0100 + i * 8 + s); br_target = 16'h0F00;
                br_cond = 1; #1;
                check(br_taken == e && next_pc == (e ? 16'h0F00 : cur_pc + 16'd1),
                      "R6 branch on stored bit", next_pc, e ? 16'h0F00 : cur_pc + 16'd1);
                tick();
                br_cond = 0;
            end
        end
    endtask

    task automatic t_hold();
        do_compare(16'h0004, 16'h0004, 3'b000, "R2 set bit");
        repeat (3) tick();
        check(cond_bit == 1, "R5 hold over idle", cond_bit, 1);
        br_cond = 1; cur_pc = 16'h0040; br_target = 16'h0ABC;
        tick();
        br_cond = 0; br_jump = 1;
        tick();
        br_jump = 0;
        check(cond_bit == 1, "R5 hold over branches", cond_bit, 1);
        br_cond = 1; #1;
        check(br_taken && next_pc == 16'h0ABC, "R6 taken after hold", next_pc, 16'h0ABC);
        br_cond = 0;
    endtask

    task automatic t_jump();
        do_compare(16'h0004, 16'h0004, 3'b100, "R2 clear bit");
        cur_pc = 16'h0300; br_target = 16'h0777; br_jump = 1; #1;
        check(br_taken && next_pc == 16'h0777, "R8 jump with clear bit", next_pc, 16'h0777);
        br_cond = 1; #1;
        check(br_taken && next_pc == 16'h0777, "R8 jump beats cond", next_pc, 16'h0777);
        br_jump = 0; #1;
        check(!br_taken && next_pc == 16'h0301, "R6 cond alone not taken", next_pc, 16'h0301);
        br_cond = 0;
    endtask

    task automatic t_same_cycle();
        do_compare(16'h0001, 16'h0002, 3'b001, "R2 set via N");
        cmp_valid = 1; cmp_a = 16'h0002; cmp_b = 16'h0001; cmp_sel = 3'b001;
        br_cond = 1; cur_pc = 16'h0500; br_target = 16'h0600; #1;
        check(br_taken && next_pc == 16'h0600, "R9 old bit used", next_pc, 16'h0600);
        tick();
        cmp_valid = 0;
        check(cond_bit == 0, "R9 new bit stored", cond_bit, 0);
        check(!br_taken && next_pc == 16'h0501, "R9 later branch sees new bit",
              next_pc, 16'h0501);
        br_cond = 0;
    endtask

    task automatic t_wrap();
        cur_pc = 16'hFFFF; br_cond = 1; br_target = 16'h0042; #1;
        check(!br_taken && next_pc == 16'h0000, "R7 wrap", next_pc, 0);
        br_cond = 0;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_sweep();
        t_hold();
        t_jump();
        t_same_cycle();
        t_wrap();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule